// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

This block is the pending-interrupt core of a processor-local interrupt controller. It keeps three 256-bit vectors: requested, in service, and trigger mode. It finds the highest pending vector and decides whether that vector is urgent enough to interrupt the core. It does this by comparing the vector's priority class (bits 7:4) with the processor priority.

Sources post vectors, each with a trigger mode. The core writes its task priority as a 4-bit value. When the core takes an interrupt it pulses acknowledge, and the block moves the winning vector from requested to in service. If the vector is blocked by the task priority, the block returns the spurious vector instead. When the core finishes a handler it pulses end-of-interrupt. The block then retires the highest in-service vector and reports that vector together with its trigger mode, so that level-triggered sources can be re-armed. An INIT pulse clears all interrupt state.

Top module: `vec_prio_resolver`

## Requirements
- R1: A post pulse sets the request bit of `post_vec`. The vector stays pending until an acknowledge selects it or INIT clears it.
- R2: Among pending requests a higher vector number has higher priority. Acknowledges return pending vectors in descending numeric order. Vector 0x00 is a valid vector.
- R3: While bit 8 of the spurious register (software enable) is 0, `irq` stays 0. An acknowledge in that state returns the spurious vector and leaves the request and in-service vectors unchanged.
- R4: `irq` is 1 only when a request is pending and the enable bit is set, and either the processor priority is 0x00 or bits 7:4 of the highest request are strictly greater than bits 7:4 of the processor priority.
- R5: Acknowledge with a pending request clears that request bit. If the task priority is nonzero and the vector is less than or equal to it, `ack_spur`=1 and `ack_vec` is the low byte of the spurious register. Otherwise the in-service bit is set, `ack_spur`=0 and `ack_vec` is the vector. Acknowledge with nothing pending returns the spurious vector with `ack_spur`=1.
- R6: End-of-interrupt clears the highest set in-service bit and pulses `eoi_done` with that vector on `eoi_vec`. With no in-service bit set it does nothing and `eoi_done` stays 0.
- R7: A task-priority write stores `tpr_nib` in bits 7:4 with bits 3:0 zero. The spurious register is 9 bits wide and resets to 0x0FF, so after reset the block is disabled and its spurious vector is 0xFF.
- R8: An INIT pulse clears the request, in-service and trigger-mode vectors and the task priority. It leaves the spurious register unchanged.
- R9: `ppr` equals the task priority when the task priority's bits 7:4 are at least those of the highest in-service vector. Otherwise `ppr` equals the in-service vector's bits 7:4 followed by four zero bits. An empty in-service vector counts as class 0.
- R10: A post records its trigger mode: level (1) sets the vector's trigger-mode bit and edge (0) clears it. `eoi_level` reports this bit for the retired vector.
- R11: After reset, `irq`, `ppr`, `ack_done` and `eoi_done` are 0.
- R12: All outputs are registered. A state change made at a clock edge appears on `irq` and `ppr` at the following edge. `ack_done` and `eoi_done` rise at the edge that samples their strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | Post a vector this cycle |
| post_vec | input | 8 | Vector being posted |
| post_level | input | 1 | 1 = level triggered, 0 = edge triggered |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_nib | input | 4 | Task-priority class to store |
| svr_wr | input | 1 | Spurious-register write strobe |
| svr_data | input | 9 | Bit 8 = software enable, bits 7:0 = spurious vector |
| init | input | 1 | INIT event: clear interrupt state |
| ack | input | 1 | Core acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq | output | 1 | Interrupt request to the core |
| ppr | output | 8 | Current processor priority |
| ack_done | output | 1 | Acknowledge result valid |
| ack_vec | output | 8 | Vector delivered for the acknowledge |
| ack_spur | output | 1 | Delivered vector is the spurious vector |
| eoi_done | output | 1 | A vector was retired |
| eoi_vec | output | 8 | Retired vector |
| eoi_level | output | 1 | Trigger mode of the retired vector |

## Verification
The bench posts a mix of vectors: some in different priority classes, some in the same class, and one set in ascending order that includes 0x00 and 0xFF. The order in which they come back shows whether the priority search is correct across the whole range. Task-priority values are chosen right at a vector's boundary, and equal in class to a pending vector. These separate the `<=` spurious rule from the strictly-greater class rule that gates `irq`. End-of-interrupt sequences with mixed trigger modes, plus one issued with nothing in service, check the retirement order and the recorded trigger mode. Acknowledges made while disabled and after INIT show that the spurious path changes no state.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
  localparam int VPR_VW   = 8;
  localparam int VPR_CLSW = 4;
  typedef logic [VPR_VW-1:0] vpr_vec_t;
  typedef struct packed {
    logic     en;
    vpr_vec_t idx;
    logic     val;
  } vpr_bitop_t;
endpackage

// File: rtl/vpr_prio_enc.sv
module vpr_prio_enc #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        valid = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vpr_bitvec.sv
module vpr_bitvec #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_all,
  input  logic          a_en,
  input  logic [IW-1:0] a_idx,
  input  logic          a_val,
  input  logic          b_en,
  input  logic [IW-1:0] b_idx,
  input  logic          b_val,
  output logic [N-1:0]  q
);
  // port b is applied after port a, so it wins on the same bit
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      q <= '0;
    end else begin
      if (a_en) q[a_idx] <= a_val;
      if (b_en) q[b_idx] <= b_val;
    end
  end
endmodule

// File: rtl/vpr_prio_calc.sv
module vpr_prio_calc #(
  parameter int VW   = 8,
  parameter int CLSW = 4
) (
  input  logic          en,
  input  logic [VW-1:0] tpr,
  input  logic          isr_valid,
  input  logic [VW-1:0] isr_top,
  input  logic          irr_valid,
  input  logic [VW-1:0] irr_top,
  output logic [VW-1:0] ppr,
  output logic          want_irq
);
  localparam int SUBW = VW - CLSW;

  logic [CLSW-1:0] isr_cls;
  logic [CLSW-1:0] tpr_cls;

  always_comb begin
    isr_cls = isr_valid ? isr_top[VW-1:SUBW] : '0;
    tpr_cls = tpr[VW-1:SUBW];
    if (tpr_cls >= isr_cls) ppr = tpr;
    else                    ppr = {isr_cls, {SUBW{1'b0}}};
    want_irq = en && irr_valid &&
               ((ppr == '0) || (irr_top[VW-1:SUBW] > ppr[VW-1:SUBW]));
  end
endmodule

// File: rtl/vec_prio_resolver.sv
module vec_prio_resolver
  import vpr_pkg::*;
#(
  parameter int VW   = VPR_VW,
  parameter int CLSW = VPR_CLSW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          post_valid,
  input  logic [VW-1:0] post_vec,
  input  logic          post_level,
  input  logic          tpr_wr,
  input  logic [CLSW-1:0] tpr_nib,
  input  logic          svr_wr,
  input  logic [VW:0]   svr_data,
  input  logic          init,
  input  logic          ack,
  input  logic          eoi,
  output logic          irq,
  output logic [VW-1:0] ppr,
  output logic          ack_done,
  output logic [VW-1:0] ack_vec,
  output logic          ack_spur,
  output logic          eoi_done,
  output logic [VW-1:0] eoi_vec,
  output logic          eoi_level
);
  localparam int NVEC  = 1 << VW;
  localparam int SUBW  = VW - CLSW;
  localparam logic [VW:0] SVR_RST = {1'b0, {VW{1'b1}}};

  logic [NVEC-1:0] irr_q, isr_q, tmr_q;
  logic [VW-1:0]   tpr_q;
  logic [VW:0]     svr_q;
  logic            irr_valid, isr_valid;
  logic [VW-1:0]   irr_top, isr_top;
  logic [VW-1:0]   ppr_c;
  logic            want_irq;
  logic            sw_en, ack_grant, ack_blocked, eoi_hit;
  vpr_bitop_t      irr_a, irr_b, isr_a, isr_b, tmr_b;

  assign sw_en       = svr_q[VW];
  assign ack_grant   = ack && sw_en && irr_valid;
  assign ack_blocked = (tpr_q != '0) && (irr_top <= tpr_q);
  assign eoi_hit     = eoi && isr_valid;

  always_comb begin
    irr_a = '{en: ack_grant,                idx: irr_top,  val: 1'b0};
    irr_b = '{en: post_valid,               idx: post_vec, val: 1'b1};
    isr_a = '{en: eoi_hit,                  idx: isr_top,  val: 1'b0};
    isr_b = '{en: ack_grant && !ack_blocked, idx: irr_top, val: 1'b1};
    tmr_b = '{en: post_valid,               idx: post_vec, val: post_level};
  end

  vpr_bitvec #(.N(NVEC), .IW(VW)) u_irr (
    .clk, .rst, .clr_all(init),
    .a_en(irr_a.en), .a_idx(irr_a.idx), .a_val(irr_a.val),
    .b_en(irr_b.en), .b_idx(irr_b.idx), .b_val(irr_b.val),
    .q(irr_q)
  );

  vpr_bitvec #(.N(NVEC), .IW(VW)) u_isr (
    .clk, .rst, .clr_all(init),
    .a_en(isr_a.en), .a_idx(isr_a.idx), .a_val(isr_a.val),
    .b_en(isr_b.en), .b_idx(isr_b.idx), .b_val(isr_b.val),
    .q(isr_q)
  );

  vpr_bitvec #(.N(NVEC), .IW(VW)) u_tmr (
    .clk, .rst, .clr_all(init),
    .a_en(1'b0), .a_idx('0), .a_val(1'b0),
    .b_en(tmr_b.en), .b_idx(tmr_b.idx), .b_val(tmr_b.val),
    .q(tmr_q)
  );

  vpr_prio_enc #(.N(NVEC), .IW(VW)) u_irr_enc (
    .bits(irr_q), .valid(irr_valid), .idx(irr_top)
  );

  vpr_prio_enc #(.N(NVEC), .IW(VW)) u_isr_enc (
    .bits(isr_q), .valid(isr_valid), .idx(isr_top)
  );

  vpr_prio_calc #(.VW(VW), .CLSW(CLSW)) u_calc (
    .en(sw_en), .tpr(tpr_q),
    .isr_valid, .isr_top, .irr_valid, .irr_top,
    .ppr(ppr_c), .want_irq
  );

  always_ff @(posedge clk) begin
    if (rst || init)  tpr_q <= '0;
    else if (tpr_wr)  tpr_q <= {tpr_nib, {SUBW{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst)         svr_q <= SVR_RST;
    else if (svr_wr) svr_q <= svr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      ppr       <= '0;
      ack_done  <= 1'b0;
      ack_vec   <= '0;
      ack_spur  <= 1'b0;
      eoi_done  <= 1'b0;
      eoi_vec   <= '0;
      eoi_level <= 1'b0;
    end else begin
      irq       <= want_irq;
      ppr       <= ppr_c;
      ack_done  <= ack;
      ack_spur  <= !ack_grant || ack_blocked;
      ack_vec   <= (ack_grant && !ack_blocked) ? irr_top : svr_q[VW-1:0];
      eoi_done  <= eoi_hit;
      eoi_vec   <= isr_top;
      eoi_level <= tmr_q[isr_top];
    end
  end
endmodule

// File: rtl/vpr_checker.sv
module vpr_checker #(
  parameter int VW = 8,
  parameter int NVEC = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            init,
  input logic            ack,
  input logic            eoi,
  input logic            irq,
  input logic            ack_done,
  input logic [VW-1:0]   ack_vec,
  input logic            ack_spur,
  input logic            eoi_done,
  input logic [NVEC-1:0] irr_q,
  input logic [NVEC-1:0] isr_q,
  input logic [VW-1:0]   tpr_q,
  input logic [VW:0]     svr_q
);
  p_irq_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
    !svr_q[VW] |=> !irq);

  p_ack_result_r5: assert property (@(posedge clk) disable iff (rst)
    ack_done && !ack_spur |-> isr_q[ack_vec]);

  p_ack_follows_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    ack |=> ack_done);

  p_eoi_follows_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    eoi_done |-> $past(eoi));

  p_tpr_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
    tpr_q[3:0] == 4'h0);

  p_init_clears_r8: assert property (@(posedge clk) disable iff (rst)
    init |=> (irr_q == '0) && (isr_q == '0) && (tpr_q == '0));
endmodule

bind vec_prio_resolver vpr_checker #(.VW(VW), .NVEC(NVEC)) u_chk (
  .clk(clk), .rst(rst), .init(init), .ack(ack), .eoi(eoi), .irq(irq),
  .ack_done(ack_done), .ack_vec(ack_vec), .ack_spur(ack_spur),
  .eoi_done(eoi_done), .irr_q(irr_q), .isr_q(isr_q),
  .tpr_q(tpr_q), .svr_q(svr_q)
);

// File: tb/test_vec_prio_resolver.sv
module test_vec_prio_resolver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       post_valid = 0, post_level = 0, tpr_wr = 0, svr_wr = 0;
  logic       init = 0, ack = 0, eoi = 0;
  logic [7:0] post_vec = 0;
  logic [3:0] tpr_nib = 0;
  logic [8:0] svr_data = 0;
  logic       irq, ack_done, ack_spur, eoi_done, eoi_level;
  logic [7:0] ppr, ack_vec, eoi_vec;

  int tests = 0;
  int fails = 0;
  logic [8:0] ack_q[$];
  logic [8:0] eoi_q[$];
  bit finished = 0;

  always #2 clk = ~clk;

  vec_prio_resolver i_vec_prio_resolver (
    .clk, .rst, .post_valid, .post_vec, .post_level, .tpr_wr, .tpr_nib,
    .svr_wr, .svr_data, .init, .ack, .eoi, .irq, .ppr, .ack_done,
    .ack_vec, .ack_spur, .eoi_done, .eoi_vec, .eoi_level
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_post(logic [7:0] v, logic lvl);
    post_valid = 1; post_vec = v; post_level = lvl;
    @(negedge clk);
    post_valid = 0;
  endtask

  task automatic do_tpr(logic [3:0] n);
    tpr_wr = 1; tpr_nib = n;
    @(negedge clk);
    tpr_wr = 0;
  endtask

  task automatic do_svr(logic [8:0] d);
    svr_wr = 1; svr_data = d;
    @(negedge clk);
    svr_wr = 0;
  endtask

  task automatic do_ack(logic [7:0] ev, logic es);
    ack_q.push_back({es, ev});
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic do_eoi(logic [7:0] ev, logic el, bit expect_one);
    if (expect_one) eoi_q.push_back({el, ev});
    eoi = 1;
    @(negedge clk);
    eoi = 0;
  endtask

  // monitor: compare produced results against the scoreboard queues
  always @(negedge clk) begin
    if (!rst && ack_done) begin
      if (ack_q.size() == 0) chk("R5 unexpected ack", {23'd0, ack_spur, ack_vec}, 32'h1ff);
      else begin
        logic [8:0] e;
        e = ack_q.pop_front();
        chk("R5 ack result", {23'd0, ack_spur, ack_vec}, {23'd0, e});
      end
    end
    if (!rst && eoi_done) begin
      if (eoi_q.size() == 0) chk("R6 unexpected eoi", {23'd0, eoi_level, eoi_vec}, 32'h1ff);
      else begin
        logic [8:0] e;
        e = eoi_q.pop_front();
        chk("R6 R10 eoi result", {23'd0, eoi_level, eoi_vec}, {23'd0, e});
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", irq, 0);
    chk("R11 ppr", ppr, 0);
    chk("R11 ack_done", ack_done, 0);
    chk("R11 eoi_done", eoi_done, 0);
    // R7 reset spurious 0xFF, disabled
    do_ack(8'hFF, 1);
    settle();
    do_svr(9'h13F);
    // R1 R2 R4 class gating
    do_post(8'h45, 0);
    do_post(8'h92, 1);
    settle();
    chk("R1 R4 irq after post", irq, 1);
    do_ack(8'h92, 0);
    settle();
    chk("R9 ppr from isr", ppr, 8'h90);
    chk("R4 lower class blocked", irq, 0);
    do_post(8'hA1, 0);
    settle();
    chk("R4 higher class irq", irq, 1);
    do_ack(8'hA1, 0);
    settle();
    chk("R9 ppr A0", ppr, 8'hA0);
    chk("R12 irq drops", irq, 0);
    do_eoi(8'hA1, 0, 1);
    settle();
    chk("R6 ppr after eoi", ppr, 8'h90);
    do_eoi(8'h92, 1, 1);
    settle();
    chk("R6 ppr empty isr", ppr, 8'h00);
    chk("R4 ppr zero irq", irq, 1);
    do_eoi(8'h00, 0, 0);
    settle();
    // R7 R9 task priority
    do_tpr(4'h5);
    settle();
    chk("R7 R9 ppr from tpr", ppr, 8'h50);
    chk("R4 class 4 under 5", irq, 0);
    do_ack(8'h3F, 1);
    do_ack(8'h3F, 1);
    do_eoi(8'h00, 0, 0);
    do_post(8'h50, 0);
    settle();
    chk("R4 equal vector no irq", irq, 0);
    do_ack(8'h3F, 1);
    do_post(8'h51, 0);
    settle();
    chk("R4 equal class no irq", irq, 0);
    do_ack(8'h51, 0);
    settle();
    chk("R9 tpr class wins tie", ppr, 8'h50);
    do_eoi(8'h51, 0, 1);
    // R3 disable
    do_svr(9'h03F);
    do_post(8'hF0, 0);
    settle();
    chk("R3 disabled irq", irq, 0);
    do_ack(8'h3F, 1);
    do_svr(9'h13F);
    settle();
    chk("R3 request kept", irq, 1);
    do_ack(8'hF0, 0);
    do_eoi(8'hF0, 0, 1);
    settle();
    // R8 INIT
    do_post(8'h33, 1);
    do_tpr(4'h2);
    init = 1;
    @(negedge clk);
    init = 0;
    settle();
    chk("R8 irq cleared", irq, 0);
    chk("R8 ppr cleared", ppr, 0);
    do_ack(8'h3F, 1);
    do_eoi(8'h00, 0, 0);
    // R2 ordering over full range, R10 trigger modes
    do_post(8'h20, 0);
    do_post(8'h21, 0);
    do_post(8'h7F, 1);
    do_post(8'h80, 0);
    do_post(8'hFF, 0);
    do_post(8'h00, 0);
    do_ack(8'hFF, 0);
    do_ack(8'h80, 0);
    do_ack(8'h7F, 0);
    do_ack(8'h21, 0);
    do_ack(8'h20, 0);
    do_ack(8'h00, 0);
    settle();
    chk("R9 ppr top class", ppr, 8'hF0);
    do_eoi(8'hFF, 0, 1);
    do_eoi(8'h80, 0, 1);
    do_eoi(8'h7F, 1, 1);
    do_eoi(8'h21, 0, 1);
    do_eoi(8'h20, 0, 1);
    do_eoi(8'h00, 0, 1);
    settle();
    chk("R2 ack queue drained", ack_q.size(), 0);
    chk("R6 eoi queue drained", eoi_q.size(), 0);
    finished = 1;
    summary();
  end
endmodule